// File: doc/BRIEF.md
# Debug Instruction and Data Transfer Chains

This block holds two debug scan chains that a TAP controller next to it shifts through. The instruction chain carries a 32-bit opcode out to the core. The data chain moves 32-bit words in either direction between the debug host and the core. The neighbouring block supplies the chain number and the TAP state strobes: Capture-DR, Shift-DR, Update-DR and a Run-Test/Idle level. It also supplies two direction flags that stand for the two data-chain instructions, one for host-to-core loads and one for core-to-host reads. All of these are synchronous to `clk`.

Each scan captures a Ready bit that tells the host whether the transfer will be accepted. Ready is sampled once, at Capture-DR, and the later Update-DR only takes effect when that sample was 1. If the host reads Ready as 0, it repeats the scan. A loaded opcode runs when the TAP enters Run-Test/Idle after an accepted scan. That run is reported to the core as a one-cycle request and ends when the core acknowledges it. On the core side there is a host-to-core data word with a full flag, which the core empties with a take strobe. There is also a core-to-host word that the core fills with a write strobe.

Top module: `dbg_xfer_chains`

## Requirements
- R1: The instruction chain (chain number 4) is 33 bits long and is shifted LSB first. Bits 31:0 hold the opcode and bit 32 holds Ready. At capture, bits 31:0 read as 0 and bit 32 reads as the current Ready value.
- R2: An Update-DR on chain 4 loads bits 31:0 into `instr` only if Ready was 1 at the Capture-DR of the same scan. Otherwise `instr` keeps its value.
- R3: The data chain (chain number 5) is 34 bits long and is shifted LSB first: bits 31:0 hold data, bit 32 holds Ready and bit 33 holds the retry flag. The retry flag always reads as the inverse of Ready. Ready is 1 only when no opcode is executing and one of these holds: chain 4 is selected; chain 5 is selected in host-to-core mode with the host-to-core word empty; or chain 5 is selected in core-to-host mode with the core-to-host word full.
- R4: `exec_req` pulses high for exactly one cycle, in the cycle after the TAP enters Run-Test/Idle. For this to happen, all of the following must hold: a scan on chain 4 or 5 has completed its Update-DR with Ready captured as 1 since the last Capture-DR on those chains, an opcode has been loaded, and `exec_en` is 1. The block then stays busy until `exec_ack` is high.
- R5: Remaining in Run-Test/Idle for many cycles gives one execution. Leaving the state and entering it again without a new accepted scan gives none.
- R6: With `exec_en` low, entering Run-Test/Idle gives no execution and discards the pending trigger.
- R7: An accepted host-to-core scan (`dtr_to_core`=1) loads bits 31:0 into `h2c_data` and sets `h2c_full`. The word then holds until `h2c_take` clears the flag.
- R8: An accepted core-to-host capture (`dtr_from_core`=1) returns the core word in bits 31:0 and clears `c2h_full`.
- R9: `c2h_wr` while `c2h_full` is 1 is ignored, and the held word is not replaced.
- R10: After reset, `instr` is 0, `exec_req`, `h2c_full` and `c2h_full` are 0, and `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the TAP controller |
| rst_n | input | 1 | Synchronous active-low reset |
| tdi | input | 1 | Serial data in |
| st_capture_dr | input | 1 | TAP is in Capture-DR this cycle |
| st_shift_dr | input | 1 | TAP is in Shift-DR this cycle |
| st_update_dr | input | 1 | TAP is in Update-DR this cycle |
| st_run_idle | input | 1 | TAP is in Run-Test/Idle |
| dr_chain | input | CHAIN_W | Selected scan chain number |
| dtr_to_core | input | 1 | Data chain in host-to-core mode |
| dtr_from_core | input | 1 | Data chain in core-to-host mode |
| exec_en | input | 1 | Execution enable from the debug control register |
| tdo | output | 1 | Serial data out |
| instr | output | WORD_W | Loaded opcode |
| exec_req | output | 1 | One-cycle execute strobe |
| exec_ack | input | 1 | Core finished the opcode |
| h2c_data | output | WORD_W | Host-to-core word |
| h2c_full | output | 1 | Host-to-core word valid |
| h2c_take | input | 1 | Core consumed the host-to-core word |
| c2h_wdata | input | WORD_W | Word written by the core |
| c2h_wr | input | 1 | Core write strobe |
| c2h_full | output | 1 | Core-to-host word valid |

## Verification
The assertions check several properties on every cycle: the execute strobe is a single cycle, it follows an idle entry, it never comes while busy, and it never comes with execution disabled. They also check that the opcode changes only after an Update-DR on the instruction chain, and that a full data word holds steady. Only the bench scenarios can show the Ready value a scan reads back. The same is true of a refused update leaving the registers untouched, a second idle entry without a new scan doing nothing, and dropped core writes.

// File: rtl/dbgx_pkg.sv
// Shared types for the debug transfer chains.
package dbgx_pkg;
    // Kind of transfer the current chain selection stands for.
    typedef enum logic [1:0] {
        XF_NONE = 2'd0,
        XF_ITR  = 2'd1,
        XF_H2C  = 2'd2,
        XF_C2H  = 2'd3
    } xfer_e;
endpackage

// File: rtl/dbgx_shifter.sv
// Capture/shift register for one scan chain.
// Assumes LSB-first shifting; tdo is bit 0 of the register.
module dbgx_shifter #(
    parameter int LEN = 33
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture,
    input  logic           shift,
    input  logic [LEN-1:0] cap_val,
    input  logic           si,
    output logic           so,
    output logic [LEN-1:0] par
);
    logic [LEN-1:0] sh_q;

    // Load the capture value or shift one bit toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_q <= '0;
        else if (capture) sh_q <= cap_val;
        else if (shift)   sh_q <= {si, sh_q[LEN-1:1]};
    end

    assign so  = sh_q[0];
    assign par = sh_q;
endmodule

// File: rtl/dbgx_exec_ctl.sv
// Opcode register and execute trigger.
// Fires once per idle entry after an accepted scan; busy until the core acks.
module dbgx_exec_ctl #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_idle,
    input  logic              arm_set,
    input  logic              arm_clr,
    input  logic              load_instr,
    input  logic [WORD_W-1:0] instr_in,
    input  logic              exec_en,
    input  logic              exec_ack,
    output logic [WORD_W-1:0] instr,
    output logic              exec_req,
    output logic              busy
);
    logic idle_q, arm_q, have_q;
    logic idle_entry, fire;

    assign idle_entry = run_idle && !idle_q;
    assign fire       = idle_entry && arm_q && have_q && exec_en && !busy;

    // Track the previous idle level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) idle_q <= 1'b0;
        else        idle_q <= run_idle;
    end

    // Pending trigger: set by an accepted update, consumed by any idle entry or new capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                      arm_q <= 1'b0;
        else if (idle_entry || arm_clr)  arm_q <= 1'b0;
        else if (arm_set)                arm_q <= 1'b1;
    end

    // Opcode register and loaded flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr  <= '0;
            have_q <= 1'b0;
        end else if (load_instr) begin
            instr  <= instr_in;
            have_q <= 1'b1;
        end
    end

    // Execute strobe and busy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_req <= 1'b0;
            busy     <= 1'b0;
        end else begin
            exec_req <= fire;
            if (fire)          busy <= 1'b1;
            else if (exec_ack) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/dbgx_dtr_regs.sv
// Host-to-core and core-to-host data words with full flags.
// Assumes loads arrive only when empty and drains only when full.
module dbgx_dtr_regs #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h2c_load,
    input  logic [WORD_W-1:0] h2c_in,
    input  logic              h2c_take,
    output logic [WORD_W-1:0] h2c_data,
    output logic              h2c_full,
    input  logic              c2h_wr,
    input  logic [WORD_W-1:0] c2h_wdata,
    input  logic              c2h_drain,
    output logic [WORD_W-1:0] c2h_word,
    output logic              c2h_full
);
    // Host-to-core word: loaded by the scan, emptied by the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h2c_data <= '0;
            h2c_full <= 1'b0;
        end else if (h2c_load) begin
            h2c_data <= h2c_in;
            h2c_full <= 1'b1;
        end else if (h2c_take) begin
            h2c_full <= 1'b0;
        end
    end

    // Core-to-host word: written by the core when empty, emptied by a ready capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c2h_word <= '0;
            c2h_full <= 1'b0;
        end else if (c2h_wr && !c2h_full) begin
            c2h_word <= c2h_wdata;
            c2h_full <= 1'b1;
        end else if (c2h_drain) begin
            c2h_full <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_xfer_chains.sv
// Instruction chain and data chain behind a debug TAP.
// Assumes TAP strobes and chain number are synchronous to clk and stable per scan.
module dbg_xfer_chains #(
    parameter int WORD_W    = 32,
    parameter int CHAIN_W   = 4,
    parameter int ITR_CHAIN = 4,
    parameter int DTR_CHAIN = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tdi,
    input  logic               st_capture_dr,
    input  logic               st_shift_dr,
    input  logic               st_update_dr,
    input  logic               st_run_idle,
    input  logic [CHAIN_W-1:0] dr_chain,
    input  logic               dtr_to_core,
    input  logic               dtr_from_core,
    input  logic               exec_en,
    output logic               tdo,
    output logic [WORD_W-1:0]  instr,
    output logic               exec_req,
    input  logic               exec_ack,
    output logic [WORD_W-1:0]  h2c_data,
    output logic               h2c_full,
    input  logic               h2c_take,
    input  logic [WORD_W-1:0]  c2h_wdata,
    input  logic               c2h_wr,
    output logic               c2h_full
);
    import dbgx_pkg::*;

    localparam int ITR_LEN = WORD_W + 1;
    localparam int DTR_LEN = WORD_W + 2;

    xfer_e kind;
    logic  sel_itr, sel_dtr, ready_now, rdy_q, busy, accept;
    logic  [WORD_W-1:0]  c2h_word;
    logic  [ITR_LEN-1:0] itr_cap, itr_par;
    logic  [DTR_LEN-1:0] dtr_cap, dtr_par;
    logic  itr_so, dtr_so;

    assign sel_itr = (dr_chain == CHAIN_W'(ITR_CHAIN));
    assign sel_dtr = (dr_chain == CHAIN_W'(DTR_CHAIN));

    // Decode the transfer kind from chain and direction.
    always_comb begin
        kind = XF_NONE;
        if (sel_itr)                                   kind = XF_ITR;
        else if (sel_dtr && dtr_to_core && !dtr_from_core) kind = XF_H2C;
        else if (sel_dtr && dtr_from_core && !dtr_to_core) kind = XF_C2H;
    end

    // Ready for the current selection.
    always_comb begin
        unique case (kind)
            XF_ITR:  ready_now = !busy;
            XF_H2C:  ready_now = !busy && !h2c_full;
            XF_C2H:  ready_now = !busy && c2h_full;
            default: ready_now = 1'b0;
        endcase
    end

    // Remember Ready as seen at capture.
    always_ff @(posedge clk) begin
        if (!rst_n)             rdy_q <= 1'b0;
        else if (st_capture_dr) rdy_q <= ready_now;
    end

    assign accept  = st_update_dr && rdy_q && (kind != XF_NONE);
    assign itr_cap = {ready_now, {WORD_W{1'b0}}};
    assign dtr_cap = {!ready_now, ready_now,
                      (kind == XF_C2H) ? c2h_word : {WORD_W{1'b0}}};

    dbgx_shifter #(.LEN(ITR_LEN)) u_itr_sh (
        .clk(clk), .rst_n(rst_n),
        .capture(st_capture_dr && sel_itr), .shift(st_shift_dr && sel_itr),
        .cap_val(itr_cap), .si(tdi), .so(itr_so), .par(itr_par)
    );

    dbgx_shifter #(.LEN(DTR_LEN)) u_dtr_sh (
        .clk(clk), .rst_n(rst_n),
        .capture(st_capture_dr && sel_dtr), .shift(st_shift_dr && sel_dtr),
        .cap_val(dtr_cap), .si(tdi), .so(dtr_so), .par(dtr_par)
    );

    assign tdo = sel_itr ? itr_so : (sel_dtr ? dtr_so : 1'b0);

    dbgx_exec_ctl #(.WORD_W(WORD_W)) u_exec (
        .clk(clk), .rst_n(rst_n), .run_idle(st_run_idle),
        .arm_set(accept), .arm_clr(st_capture_dr && (sel_itr || sel_dtr)),
        .load_instr(accept && kind == XF_ITR), .instr_in(itr_par[WORD_W-1:0]),
        .exec_en(exec_en), .exec_ack(exec_ack),
        .instr(instr), .exec_req(exec_req), .busy(busy)
    );

    dbgx_dtr_regs #(.WORD_W(WORD_W)) u_dtr (
        .clk(clk), .rst_n(rst_n),
        .h2c_load(accept && kind == XF_H2C), .h2c_in(dtr_par[WORD_W-1:0]),
        .h2c_take(h2c_take), .h2c_data(h2c_data), .h2c_full(h2c_full),
        .c2h_wr(c2h_wr), .c2h_wdata(c2h_wdata),
        .c2h_drain(st_capture_dr && kind == XF_C2H && ready_now),
        .c2h_word(c2h_word), .c2h_full(c2h_full)
    );
endmodule

// File: rtl/dbg_xfer_chains_chk.sv
// Cycle-level properties of the transfer chains, bound into the top module.
module dbg_xfer_chains_chk #(
    parameter int WORD_W    = 32,
    parameter int CHAIN_W   = 4,
    parameter int ITR_CHAIN = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               st_update_dr,
    input logic               st_run_idle,
    input logic [CHAIN_W-1:0] dr_chain,
    input logic               exec_en,
    input logic               exec_req,
    input logic               busy,
    input logic [WORD_W-1:0]  instr,
    input logic [WORD_W-1:0]  h2c_data,
    input logic               h2c_full,
    input logic [WORD_W-1:0]  c2h_word,
    input logic               c2h_full
);
    // R4: execute strobe lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |=> !exec_req);
    // R5: execution only right after an idle entry
    a_r5_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |-> ($past(st_run_idle) && !$past(st_run_idle, 2)));
    // R6: no execution with execution disabled
    a_r6_exec_gated: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |-> $past(exec_en));
    // R3: never start while an opcode is running
    a_r3_no_exec_busy: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |-> !$past(busy));
    // R2: opcode changes only after an instruction-chain update
    a_r2_instr_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(instr) |-> ($past(st_update_dr) && $past(dr_chain) == CHAIN_W'(ITR_CHAIN)));
    // R7: a full host-to-core word holds
    a_r7_h2c_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (h2c_full && $past(h2c_full)) |-> $stable(h2c_data));
    // R9: a full core-to-host word holds
    a_r9_c2h_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (c2h_full && $past(c2h_full)) |-> $stable(c2h_word));
endmodule

bind dbg_xfer_chains dbg_xfer_chains_chk #(
    .WORD_W(WORD_W), .CHAIN_W(CHAIN_W), .ITR_CHAIN(ITR_CHAIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .st_update_dr(st_update_dr), .st_run_idle(st_run_idle),
    .dr_chain(dr_chain), .exec_en(exec_en), .exec_req(exec_req), .busy(busy),
    .instr(instr), .h2c_data(h2c_data), .h2c_full(h2c_full),
    .c2h_word(c2h_word), .c2h_full(c2h_full)
);

// File: tb/tb_dbg_xfer_chains.sv
module tb_dbg_xfer_chains;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tdi = 1'b0, st_capture_dr = 1'b0, st_shift_dr = 1'b0, st_update_dr = 1'b0;
    logic        st_run_idle = 1'b0;
    logic [3:0]  dr_chain = 4'd0;
    logic        dtr_to_core = 1'b0, dtr_from_core = 1'b0, exec_en = 1'b1;
    logic        tdo, exec_req, h2c_full, c2h_full;
    logic        exec_ack = 1'b0, h2c_take = 1'b0, c2h_wr = 1'b0;
    logic [31:0] instr, h2c_data, c2h_wdata = 32'd0;

    int compared = 0, mismatched = 0, exec_cnt = 0, ack_dly = 2, ack_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dbg_xfer_chains dut (
        .clk(clk), .rst_n(rst_n), .tdi(tdi), .st_capture_dr(st_capture_dr),
        .st_shift_dr(st_shift_dr), .st_update_dr(st_update_dr), .st_run_idle(st_run_idle),
        .dr_chain(dr_chain), .dtr_to_core(dtr_to_core), .dtr_from_core(dtr_from_core),
        .exec_en(exec_en), .tdo(tdo), .instr(instr), .exec_req(exec_req),
        .exec_ack(exec_ack), .h2c_data(h2c_data), .h2c_full(h2c_full),
        .h2c_take(h2c_take), .c2h_wdata(c2h_wdata), .c2h_wr(c2h_wr), .c2h_full(c2h_full)
    );

    // Stub core: acknowledge each request after ack_dly cycles; count requests.
    always @(posedge clk) begin
        exec_ack <= 1'b0;
        if (exec_req) begin
            exec_cnt <= exec_cnt + 1;
            ack_cnt  <= ack_dly;
        end else if (ack_cnt > 0) begin
            ack_cnt <= ack_cnt - 1;
            if (ack_cnt == 1) exec_ack <= 1'b1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // One full DR scan: capture, shift len bits LSB first, update.
    task automatic scan(input int chain, input bit to_c, input bit from_c,
                        input logic [33:0] din, output logic [33:0] dout);
        int len;
        len = (chain == 4) ? 33 : 34;
        dout = '0;
        @(negedge clk);
        dr_chain = 4'(chain); dtr_to_core = to_c; dtr_from_core = from_c;
        st_capture_dr = 1'b1;
        @(negedge clk);
        st_capture_dr = 1'b0;
        for (int i = 0; i < len; i++) begin
            dout[i] = tdo; tdi = din[i]; st_shift_dr = 1'b1;
            @(negedge clk);
        end
        st_shift_dr = 1'b0; st_update_dr = 1'b1;
        @(negedge clk);
        st_update_dr = 1'b0;
    endtask

    task automatic idle(input int n);
        st_run_idle = 1'b1;
        repeat (n) @(negedge clk);
        st_run_idle = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_take();
        h2c_take = 1'b1; @(negedge clk); h2c_take = 1'b0; @(negedge clk);
    endtask

    task automatic core_write(input logic [31:0] w);
        c2h_wdata = w; c2h_wr = 1'b1; @(negedge clk); c2h_wr = 1'b0; @(negedge clk);
    endtask

    localparam int NV = 4;
    // {opcode, host-to-core word, core-to-host word}
    localparam logic [95:0] VEC [NV] = '{
        {32'hE1A00000, 32'h00000001, 32'hFFFFFFFF},
        {32'h12345678, 32'hA5A5A5A5, 32'h5A5A5A5A},
        {32'hFFFFFFFF, 32'h80000000, 32'h00000000},
        {32'h0BADF00D, 32'hDEADBEEF, 32'hCAFEF00D}
    };

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [33:0] cap;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 instr", 64'(instr), 64'd0);
        check("R10 exec_req", 64'(exec_req), 64'd0);
        check("R10 h2c_full", 64'(h2c_full), 64'd0);
        check("R10 c2h_full", 64'(c2h_full), 64'd0);
        check("R10 tdo", 64'(tdo), 64'd0);

        for (int v = 0; v < NV; v++) begin
            base = exec_cnt;
            scan(4, 0, 0, {2'b00, VEC[v][95:64]}, cap);
            check("R1 itr capture", 64'(cap[32:0]), 64'h1_0000_0000);
            check("R2 instr loaded", 64'(instr), 64'(VEC[v][95:64]));
            idle(1);
            check("R4 executed", 64'(exec_cnt), 64'(base + 1));
            repeat (ack_dly + 2) @(negedge clk);
            scan(5, 1, 0, {2'b00, VEC[v][63:32]}, cap);
            check("R3 h2c ready/retry", 64'(cap[33:32]), 64'b01);
            check("R7 h2c data", 64'(h2c_data), 64'(VEC[v][63:32]));
            check("R7 h2c full", 64'(h2c_full), 64'd1);
            pulse_take();
            check("R7 h2c taken", 64'(h2c_full), 64'd0);
            core_write(VEC[v][31:0]);
            scan(5, 0, 1, 34'd0, cap);
            check("R8 c2h data", 64'(cap[31:0]), 64'(VEC[v][31:0]));
            check("R8 c2h ready", 64'(cap[33:32]), 64'b01);
            check("R8 c2h cleared", 64'(c2h_full), 64'd0);
        end

        // Busy: refused scans do not load or trigger.
        ack_dly = 200;
        base = exec_cnt;
        scan(4, 0, 0, {2'b00, 32'h11111111}, cap);
        idle(1);
        check("R4 busy exec", 64'(exec_cnt), 64'(base + 1));
        scan(4, 0, 0, {2'b00, 32'h22222222}, cap);
        check("R3 busy ready", 64'(cap[32]), 64'd0);
        check("R2 refused load", 64'(instr), 64'h11111111);
        scan(5, 1, 0, {2'b00, 32'h33333333}, cap);
        check("R3 busy retry", 64'(cap[33:32]), 64'b10);
        check("R7 refused load", 64'(h2c_full), 64'd0);
        idle(1);
        check("R5 no exec after refused scan", 64'(exec_cnt), 64'(base + 1));
        repeat (205) @(negedge clk);
        ack_dly = 2;

        // Long idle: one execution; re-entry without new scan: none.
        base = exec_cnt;
        scan(4, 0, 0, {2'b00, 32'h44444444}, cap);
        idle(6);
        check("R5 long idle single", 64'(exec_cnt), 64'(base + 1));
        idle(1);
        check("R5 re-entry no exec", 64'(exec_cnt), 64'(base + 1));

        // Data scan re-triggers the loaded opcode.
        scan(5, 1, 0, {2'b00, 32'h55555555}, cap);
        idle(1);
        check("R4 retrigger by data scan", 64'(exec_cnt), 64'(base + 2));
        repeat (4) @(negedge clk);
        pulse_take();

        // Execution disabled.
        exec_en = 1'b0;
        base = exec_cnt;
        scan(4, 0, 0, {2'b00, 32'h66666666}, cap);
        check("R2 load while disabled", 64'(instr), 64'h66666666);
        idle(1);
        check("R6 disabled no exec", 64'(exec_cnt), 64'(base));
        exec_en = 1'b1;
        idle(1);
        check("R6 trigger discarded", 64'(exec_cnt), 64'(base));

        // Host-to-core word already full.
        scan(5, 1, 0, {2'b00, 32'h77777777}, cap);
        scan(5, 1, 0, {2'b00, 32'h88888888}, cap);
        check("R3 h2c full ready", 64'(cap[32]), 64'd0);
        check("R7 h2c hold", 64'(h2c_data), 64'h77777777);
        pulse_take();

        // Core-to-host: second write ignored; empty read refused.
        core_write(32'h99999999);
        core_write(32'hAAAAAAAA);
        scan(5, 0, 1, 34'd0, cap);
        check("R9 first word kept", 64'(cap[31:0]), 64'h99999999);
        scan(5, 0, 1, 34'd0, cap);
        check("R3 c2h empty ready", 64'(cap[33:32]), 64'b10);

        finish_run();
    end
endmodule